// File: doc/BRIEF.md
# Load/Store Port Memory Responder

This block is a single load/store port with a small private memory behind it. The memory is organised as 64-bit words. A requester starts a transfer by raising a load or a store intent. With it, the requester gives an access length of 1, 2, 4 or 8 bytes, a byte address and an address-valid flag. The block acknowledges the address one cycle later.

- For a store, the requester then gives a single-cycle data strobe.
- For a load, the block returns the data with a one-cycle valid pulse.
- An illegal access ends with a one-cycle exception pulse instead.

Busy covers the whole transfer. A requester may start only while busy is low. After a transfer finishes, the block takes no new request until address-valid has been dropped.

A block-zero variant is selected by the store intent plus a zero flag. It clears the aligned 64-byte block that holds the address, one word per cycle, and ignores the store data. The privilege input is sampled with each request. In problem state it forbids the protected low region of the memory.

Top module: `ldst_mem_port`

## Requirements
- R1: Out of reset, busy_o, addr_ack_o, ld_vld_o and exc_o are all low.
- R2: A request is accepted from idle when exactly one of ld_i and st_i is high together with addr_vld_i. addr_ack_o is then high in the cycle after acceptance, and busy_o is high from that cycle until the transfer ends.
- R3: On a legal store, the single-cycle st_vld_i pulse given while addr_ack_o is high writes len_i bytes of st_data_i[8*len_i-1:0]. The bytes are placed little-endian starting at addr_i, and all other bytes are kept. busy_o is high for exactly 2 cycles.
- R4: On a legal load, ld_vld_o pulses for one cycle, one cycle after addr_ack_o. ld_data_o then holds the bytes at addr_i right-justified (lowest address in bits 7:0) and zero-extended to 64 bits.
- R5: Two 2-byte stores at addresses A and A+2 read back through one 4-byte load at A, with the halfword at A in bits 15:0.
- R6: An access whose address is not a multiple of its length raises exc_o for one cycle and never ld_vld_o, and leaves the memory unchanged. A length other than 1, 2, 4 or 8 is treated the same way.
- R7: An access at or beyond byte MEM_BYTES (512 by default) raises exc_o and leaves the memory unchanged.
- R8: With priv_i=1 (problem state), any access or block-zero below byte PROT_BYTES (64 by default) raises exc_o. With priv_i=0 (real mode), the same access is legal.
- R9: A block-zero (st_i=1, zero_i=1) clears all 64 bytes of the block at addr_i rounded down to 64, whatever the store data. busy_o stays high for exactly BLK_WORDS+2 = 10 cycles. A block-zero that is illegal under R7 or R8 keeps busy_o high for 2 cycles and changes nothing.
- R10: st_vld_i has no effect on the memory or on busy_o when no acknowledged store is pending.
- R11: exc_o and ld_vld_o are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load intent |
| st_i | input | 1 | Store intent |
| zero_i | input | 1 | Block-zero flag, qualifies st_i |
| len_i | input | 4 | Access length in bytes: 1, 2, 4 or 8 |
| priv_i | input | 1 | 1 = problem state, 0 = real mode |
| addr_i | input | ADDR_W | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, right-justified |
| st_vld_i | input | 1 | Store data strobe, one cycle |
| busy_o | output | 1 | Transfer in progress |
| addr_ack_o | output | 1 | Address accepted |
| ld_data_o | output | 64 | Load data, right-justified, zero-extended |
| ld_vld_o | output | 1 | Load data valid, one cycle |
| exc_o | output | 1 | Illegal access, one cycle |

## Verification
The bench runs stores at every byte offset of a word, in all four lengths, and checks the neighbouring bytes with 8-byte loads. A wrong lane mask or shift would corrupt bytes next to the target, and a missing zero-extension would leave stale high bytes in load data. Misaligned, out-of-range and protected accesses are each followed by a load of the same word. A design that wrote before checking, or that pulsed load-valid alongside the exception, is caught there. Block-zero is checked for its busy length and for the exact bytes it clears, including the first and last word of the block and the next block up. A stray store strobe while idle exposes a design that writes without an acknowledged address.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ACK  = 3'd1,
    S_ZERO = 3'd2,
    S_RSP  = 3'd3,
    S_REL  = 3'd4
  } port_state_e;

  function automatic logic len_legal(input logic [3:0] len);
    return (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
  endfunction

  function automatic logic [7:0] len_mask(input logic [3:0] len);
    case (len)
      4'd1:    return 8'h01;
      4'd2:    return 8'h03;
      4'd4:    return 8'h0f;
      default: return 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/ldst_legal.sv
module ldst_legal #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 512,
  parameter int PROT_BYTES = 64,
  parameter int BLK_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        len_i,
  input  logic              zero_i,
  input  logic              priv_i,
  output logic              err_o
);
  import ldst_pkg::*;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] len_m1;
  logic              misalign, range_err, prot_err;

  always_comb begin
    base      = zero_i ? (addr_i & ~ADDR_W'(BLK_BYTES - 1)) : addr_i;
    len_m1    = ADDR_W'(len_i) - ADDR_W'(1);
    misalign  = !zero_i && (!len_legal(len_i) || ((addr_i & len_m1) != '0));
    range_err = base >= ADDR_W'(MEM_BYTES);
    prot_err  = priv_i && (base < ADDR_W'(PROT_BYTES));
    err_o     = misalign || range_err || prot_err;
  end
endmodule

// File: rtl/ldst_lanes.sv
module ldst_lanes (
  input  logic [2:0]  off_i,
  input  logic [3:0]  len_i,
  input  logic [63:0] st_data_i,
  input  logic [63:0] rd_word_i,
  output logic [7:0]  wr_mask_o,
  output logic [63:0] wr_word_o,
  output logic [63:0] ld_data_o
);
  import ldst_pkg::*;

  logic [7:0]  bmask;
  logic [63:0] shifted;
  logic [63:0] keep;

  assign bmask     = len_mask(len_i);
  assign wr_mask_o = bmask << off_i;
  assign wr_word_o = st_data_i << {off_i, 3'b000};
  assign shifted   = rd_word_i >> {off_i, 3'b000};

  for (genvar b = 0; b < 8; b++) begin : g_keep
    assign keep[8*b +: 8] = {8{bmask[b]}};
  end

  assign ld_data_o = shifted & keep;
endmodule

// File: rtl/ldst_ram.sv
module ldst_ram #(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [7:0]       wmask_i,
  input  logic [63:0]      wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [63:0]      rdata_o
);
  logic [63:0] mem [WORDS];

  for (genvar b = 0; b < 8; b++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[b]) mem[widx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/ldst_mem_port.sv
module ldst_mem_port #(
  parameter int ADDR_W     = 16,
  parameter int WORDS      = 64,
  parameter int BLK_WORDS  = 8,
  parameter int PROT_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              st_i,
  input  logic              zero_i,
  input  logic [3:0]        len_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic [63:0]       st_data_i,
  input  logic              st_vld_i,
  output logic              busy_o,
  output logic              addr_ack_o,
  output logic [63:0]       ld_data_o,
  output logic              ld_vld_o,
  output logic              exc_o
);
  import ldst_pkg::*;

  localparam int IDX_W     = $clog2(WORDS);
  localparam int BLK_W     = $clog2(BLK_WORDS);
  localparam int MEM_BYTES = WORDS * 8;
  localparam int BLK_BYTES = BLK_WORDS * 8;

  port_state_e       state_q;
  logic              ld_q, zero_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        len_q;
  logic [BLK_W-1:0]  cnt_q;
  logic [63:0]       ld_data_q;

  logic              req, err_d;
  logic [IDX_W-1:0]  word_idx, widx;
  logic [7:0]        lane_mask, wmask;
  logic [63:0]       lane_wword, lane_rdata, rd_word, wdata;
  logic              st_we, zero_we, we;

  assign req = (ld_i ^ st_i) && addr_vld_i;

  ldst_legal #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES),
    .PROT_BYTES(PROT_BYTES), .BLK_BYTES(BLK_BYTES)
  ) u_legal (
    .addr_i(addr_i), .len_i(len_i), .zero_i(st_i && zero_i),
    .priv_i(priv_i), .err_o(err_d)
  );

  assign word_idx = addr_q[3 +: IDX_W];

  ldst_lanes u_lanes (
    .off_i(addr_q[2:0]), .len_i(len_q), .st_data_i(st_data_i),
    .rd_word_i(rd_word), .wr_mask_o(lane_mask), .wr_word_o(lane_wword),
    .ld_data_o(lane_rdata)
  );

  // strobe counts only while the address is acknowledged
  assign st_we   = (state_q == S_ACK) && !ld_q && !zero_q && st_vld_i && !err_q;
  assign zero_we = (state_q == S_ZERO);
  assign we      = st_we || zero_we;
  assign widx    = zero_q ? {word_idx[IDX_W-1:BLK_W], cnt_q} : word_idx;
  assign wmask   = zero_q ? 8'hff : lane_mask;
  assign wdata   = zero_q ? 64'd0 : lane_wword;

  ldst_ram #(.WORDS(WORDS)) u_ram (
    .clk_i(clk_i), .we_i(we), .widx_i(widx), .wmask_i(wmask),
    .wdata_i(wdata), .ridx_i(word_idx), .rdata_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      ld_q      <= 1'b0;
      zero_q    <= 1'b0;
      err_q     <= 1'b0;
      addr_q    <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      ld_data_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req) begin
          ld_q    <= ld_i;
          zero_q  <= st_i && zero_i;
          err_q   <= err_d;
          addr_q  <= addr_i;
          len_q   <= len_i;
          cnt_q   <= '0;
          state_q <= S_ACK;
        end
        S_ACK: begin
          if (ld_q) begin
            ld_data_q <= lane_rdata;
            state_q   <= S_RSP;
          end else if (zero_q) begin
            state_q <= err_q ? S_RSP : S_ZERO;
          end else if (st_vld_i) begin
            state_q <= S_RSP;
          end
        end
        S_ZERO: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == BLK_W'(BLK_WORDS - 1)) state_q <= S_RSP;
        end
        S_RSP:   state_q <= addr_vld_i ? S_REL : S_IDLE;
        S_REL:   if (!addr_vld_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == S_ACK) || (state_q == S_ZERO) || (state_q == S_RSP);
  assign addr_ack_o = (state_q == S_ACK);
  assign ld_vld_o   = (state_q == S_RSP) && ld_q && !err_q;
  assign exc_o      = (state_q == S_RSP) && err_q;
  assign ld_data_o  = ld_data_q;
endmodule

// File: rtl/ldst_mem_port_chk.sv
module ldst_mem_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic addr_ack_o,
  input logic ld_vld_o,
  input logic exc_o
);
  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy_o && !addr_ack_o && !ld_vld_o && !exc_o));

  a_r2_ack_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_ack_o) |-> $past(!busy_o));

  a_r2_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ack_o |-> busy_o);

  a_r4_ld_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_vld_o) |-> $past(addr_ack_o));

  a_r11_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_vld_o && exc_o));

  a_r11_ld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_vld_o |=> !ld_vld_o);

  a_r11_exc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> !exc_o);
endmodule

bind ldst_mem_port ldst_mem_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o),
  .addr_ack_o(addr_ack_o), .ld_vld_o(ld_vld_o), .exc_o(exc_o)
);

// File: tb/ldst_mem_port_tb.sv
`timescale 1ns/1ps
module ldst_mem_port_tb;
  localparam int MEM_BYTES = 512;
  localparam int PROT      = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_i = 0, st_i = 0, zero_i = 0, priv_i = 0, addr_vld_i = 0, st_vld_i = 0;
  logic [3:0]  len_i = 0;
  logic [15:0] addr_i = 0;
  logic [63:0] st_data_i = 0;
  logic        busy_o, addr_ack_o, ld_vld_o, exc_o;
  logic [63:0] ld_data_o;

  int total = 0, bad = 0;
  logic [7:0] model [MEM_BYTES];

  always #2.5 clk_i = ~clk_i;

  ldst_mem_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_i), .st_i(st_i), .zero_i(zero_i),
    .len_i(len_i), .priv_i(priv_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
    .st_data_i(st_data_i), .st_vld_i(st_vld_i), .busy_o(busy_o),
    .addr_ack_o(addr_ack_o), .ld_data_o(ld_data_o), .ld_vld_o(ld_vld_o), .exc_o(exc_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [15:0] a, input logic [3:0] l, input bit p, input bit z);
    logic [15:0] b;
    b = z ? (a & 16'hffc0) : a;
    if (!z && !(l == 1 || l == 2 || l == 4 || l == 8)) return 1;
    if (!z && ((a % 16'(l)) != 0)) return 1;
    if (b >= MEM_BYTES) return 1;
    if (p && b < PROT) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] exp_load(input logic [15:0] a, input logic [3:0] l);
    logic [63:0] v = '0;
    for (int i = 0; i < int'(l); i++) v[8*i +: 8] = model[int'(a) + i];
    return v;
  endfunction

  task automatic do_op(input bit is_ld, input bit is_zero, input logic [15:0] a,
                       input logic [3:0] l, input bit p, input logic [63:0] d,
                       output logic [63:0] rd, output bit exc, output bit vld,
                       output int busy_n, output int ack_wait);
    bit done;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    ld_i = is_ld; st_i = !is_ld; zero_i = is_zero; len_i = l; priv_i = p;
    addr_i = a; addr_vld_i = 1;
    busy_n = 0; exc = 0; vld = 0; rd = '0; ack_wait = 0;
    @(negedge clk_i); ack_wait++;
    while (!addr_ack_o) begin @(negedge clk_i); ack_wait++; end
    if (!is_ld) begin st_data_i = d; st_vld_i = 1; end
    done = 0;
    while (!done) begin
      if (busy_o) busy_n++;
      if (exc_o) exc = 1;
      if (ld_vld_o) begin vld = 1; rd = ld_data_o; end
      if (is_ld ? (ld_vld_o || exc_o) : !busy_o) done = 1;
      else begin @(negedge clk_i); st_vld_i = 0; end
    end
    ld_i = 0; st_i = 0; zero_i = 0; addr_vld_i = 0; st_vld_i = 0;
  endtask

  task automatic store(input logic [15:0] a, input logic [3:0] l, input bit p,
                       input logic [63:0] d, input string req);
    logic [63:0] rd; bit exc, vld; int bn, aw; bit e;
    e = exp_err(a, l, p, 0);
    do_op(0, 0, a, l, p, d, rd, exc, vld, bn, aw);
    chk(aw == 1, "R2 ack one cycle after accept", 64'(aw), 64'd1);
    chk(exc == e && !vld, {req, " store exception"}, 64'(exc), 64'(e));
    chk(bn == 2, "R3 store busy cycles", 64'(bn), 64'd2);
    if (!e) for (int i = 0; i < int'(l); i++) model[int'(a) + i] = d[8*i +: 8];
  endtask

  task automatic load(input logic [15:0] a, input logic [3:0] l, input bit p, input string req);
    logic [63:0] rd; bit exc, vld; int bn, aw; bit e;
    e = exp_err(a, l, p, 0);
    do_op(1, 0, a, l, p, '0, rd, exc, vld, bn, aw);
    chk(aw == 1, "R2 ack one cycle after accept", 64'(aw), 64'd1);
    chk(exc == e && vld == !e, {req, " load completion"}, {62'd0, vld, exc}, {62'd0, !e, e});
    if (!e) chk(rd == exp_load(a, l), {req, " load data"}, rd, exp_load(a, l));
    if (!e) chk(bn == 2, "R4 load busy cycles", 64'(bn), 64'd2);
  endtask

  task automatic zero_blk(input logic [15:0] a, input bit p, input string req);
    logic [63:0] rd; bit exc, vld; int bn, aw; bit e; int b;
    e = exp_err(a, 4'd8, p, 1);
    do_op(0, 1, a, 4'd8, p, 64'hdead_beef_cafe_f00d, rd, exc, vld, bn, aw);
    chk(exc == e, {req, " zero exception"}, 64'(exc), 64'(e));
    chk(bn == (e ? 2 : 10), "R9 zero busy cycles", 64'(bn), e ? 64'd2 : 64'd10);
    if (!e) begin
      b = int'(a) & ~63;
      for (int i = 0; i < 64; i++) model[b + i] = 8'h00;
    end
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a; logic [3:0] l; bit p; int k;
    for (int i = 0; i < MEM_BYTES; i++) model[i] = '0;
    #1;
    chk(!busy_o && !addr_ack_o && !ld_vld_o && !exc_o, "R1 outputs in reset",
        {60'd0, busy_o, addr_ack_o, ld_vld_o, exc_o}, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !addr_ack_o && !ld_vld_o && !exc_o, "R1 outputs after reset",
        {60'd0, busy_o, addr_ack_o, ld_vld_o, exc_o}, 64'd0);

    // R9: clear the whole memory block by block with junk data presented
    for (int blk = 0; blk < MEM_BYTES / 64; blk++) zero_blk(16'(blk * 64 + 8), 0, "R9");
    load(16'd0, 4'd8, 0, "R9 first word cleared");
    load(16'd504, 4'd8, 0, "R9 last word cleared");

    // R3/R4: every offset and length
    for (int o = 0; o < 8; o++) store(16'(128 + o), 4'd1, 0, 64'hffff_ffff_ffff_ff00 | 64'(o + 1), "R3 byte");
    load(16'd128, 4'd8, 0, "R3 byte lanes");
    store(16'd136, 4'd8, 0, 64'h8877_6655_4433_2211, "R3 dword");
    store(16'd138, 4'd2, 0, 64'hffff_ffff_ffff_abcd, "R3 half");
    store(16'd140, 4'd4, 0, 64'hffff_ffff_1234_5678, "R3 word");
    load(16'd136, 4'd8, 0, "R3 merge");
    load(16'd143, 4'd1, 0, "R4 zero-extend byte");
    load(16'd140, 4'd4, 0, "R4 zero-extend word");

    // R5: consecutive halfwords
    store(16'd200, 4'd2, 0, 64'h0000_0000_0000_1234, "R5");
    store(16'd202, 4'd2, 0, 64'h0000_0000_0000_5678, "R5");
    load(16'd200, 4'd4, 0, "R5 combined");

    // R6/R7/R8: illegal accesses leave memory intact
    store(16'd201, 4'd2, 0, 64'hffff, "R6 misaligned");
    store(16'd204, 4'd3, 0, 64'hffff, "R6 bad length");
    load(16'd202, 4'd4, 0, "R6 misaligned load");
    store(16'd512, 4'd8, 0, 64'h1, "R7 out of range");
    load(16'd600, 4'd2, 0, "R7 out of range load");
    store(16'd16, 4'd4, 0, 64'haabb_ccdd, "R8 real mode");
    store(16'd16, 4'd4, 1, 64'h1111_2222, "R8 problem state");
    load(16'd16, 4'd4, 1, "R8 problem state load");
    load(16'd16, 4'd4, 0, "R8 real mode load");
    store(16'd64, 4'd4, 1, 64'h5555_6666, "R8 problem state above");
    zero_blk(16'd8, 1, "R8 zero protected");
    zero_blk(16'd700, 0, "R7 zero out of range");
    load(16'd200, 4'd8, 0, "R9 illegal zero kept data");
    load(16'd16, 4'd4, 0, "R9 illegal zero kept data");

    // R9: partial block and neighbours
    store(16'd256, 4'd8, 0, 64'h0102_0304_0506_0708, "R9 setup");
    store(16'd320, 4'd8, 0, 64'h1112_1314_1516_1718, "R9 setup");
    store(16'd248, 4'd8, 0, 64'h2122_2324_2526_2728, "R9 setup");
    zero_blk(16'd300, 0, "R9 mid block");
    load(16'd256, 4'd8, 0, "R9 block start");
    load(16'd320, 4'd8, 0, "R9 next block");
    load(16'd248, 4'd8, 0, "R9 previous block");

    // R10: stray strobe while idle
    @(negedge clk_i);
    addr_i = 16'd320; st_data_i = '1; st_vld_i = 1;
    @(negedge clk_i);
    chk(!busy_o, "R10 busy after stray strobe", 64'(busy_o), 64'd0);
    st_vld_i = 0;
    load(16'd320, 4'd8, 0, "R10 memory untouched");

    // random mix
    k = 0;
    for (int n = 0; n < 300; n++) begin
      k = int'($urandom(n + 17) % 4);
      l = 4'(1 << k);
      a = 16'($urandom % 560);
      if (($urandom % 8) != 0) a = a & ~(16'(l) - 16'd1);
      p = (($urandom % 4) == 0);
      case ($urandom % 8)
        0: zero_blk(a, p, "R9 random");
        1, 2, 3: store(a, l, p, {$urandom, $urandom}, "R3 random");
        default: load(a, l, p, "R4 random");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule